// File: doc/BRIEF.md
# SCSI Bus Termination Sequencer

This block settles SCSI bus termination once at boot. After a start pulse it asks for a memory port that it shares with other agents and waits, checking a ready line once per millisecond, until the port is granted or a poll limit runs out. Once it holds the port, it works through an external board-control register. Writes to that register use a strobed handshake, and reads use a read/chip-select pair.

In automatic mode the block first writes a bank select. It then reads the two sense bits of each bank to learn which of the three connectors carry a cable. From the cable count it works out the low-byte and high-byte termination. The high-byte enable goes back to the board through one more strobed write. The low-byte enable is presented at an output, where it drives the termination-power enable of the transfer logic. In manual mode both enables come directly from the adapter-control word, and no sensing takes place. The port is released at the end in both modes.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset, every output is low: port request, chip select, strobe, read line, write data, low termination, illegal flag, fail flag and done.
- R2: The port request rises on the edge that takes a start pulse and stays high until done rises. The board-control lines are active only while the request is high.
- R3: If the ready line is low at all POLL_LIMIT poll instants, fail and done rise together and the request drops. This happens on edge 1+(POLL_LIMIT-1)*TICK_CYCLES counted after the start edge, where TICK_CYCLES is CLK_HZ/1000. No board-control access takes place in that case.
- R4: Ready is sampled on the first cycle in the grant state and then every TICK_CYCLES cycles. The port counts as granted at the first sample that finds ready high. A grant at sample k delays done by k*TICK_CYCLES cycles.
- R5: A board-control write is four steps of STEP_CYCLES cycles each: chip select with strobe; the data value added; strobe dropped; chip select dropped. The board latches the value when the strobe falls, so the strobe is high for 2*STEP_CYCLES cycles.
- R6: A board-control read holds the read line and chip select high for STEP_CYCLES cycles with the strobe low and data 0. The read data is sampled on the last of those cycles.
- R7: Automatic mode is set by adapter-control bit 0 = 1. In this mode the block writes 0x00 (bank 0) and reads, then writes 0x20 (bank select on data bit 5) and reads. In bank 0, data bit 6 low means an internal 50-pin cable and bit 7 low means an internal 68-pin cable. In bank 1, bit 6 low means an external 68-pin cable, and bit 7 is ignored.
- R8: In automatic mode the last write is 0x40 when either 68-pin connector is empty, and 0x00 otherwise.
- R9: In automatic mode the low-termination output is high when at most one of the three connectors is populated.
- R10: In automatic mode the illegal flag is high when all three connectors are populated.
- R11: With adapter-control bit 0 = 0, no reads take place. A single write of 0x40 or 0x00 follows adapter-control bit 3, the low-termination output follows bit 2, and the illegal flag stays low.
- R12: Done rises on the edge that releases the request, which is edge 6+14*STEP_CYCLES (automatic) or 2+4*STEP_CYCLES (manual) after the start edge when ready is high at once. The results hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| adp_ctl_i | input | 16 | Adapter-control word (bit 0 auto, bit 2 low, bit 3 high) |
| port_req_o | output | 1 | Memory-port request |
| port_rdy_i | input | 1 | Memory-port grant |
| bc_cs_o | output | 1 | Board-control chip select |
| bc_stb_o | output | 1 | Board-control write strobe |
| bc_rw_o | output | 1 | Board-control read line |
| bc_wdata_o | output | 8 | Board-control write data |
| bc_rdata_i | input | 8 | Board-control read data |
| term_low_o | output | 1 | Low-byte termination enable |
| illegal_o | output | 1 | All three connectors populated |
| fail_o | output | 1 | Port grant timed out |
| done_o | output | 1 | Sequence finished |

## Verification
Every result is due a fixed number of edges after the start edge. A timeout ends at 1+(POLL_LIMIT-1)*TICK_CYCLES. An immediate grant ends at 6+14*STEP_CYCLES in automatic mode and at 2+4*STEP_CYCLES in manual mode. A grant at poll sample k adds k*TICK_CYCLES. The bench counts edges from the start edge, samples on the falling clock edge, and compares the count at which done appears with these figures. Board writes are scored when the strobe falls, against a queue of expected values filled before each run. The strobe width and the number of reads are checked as they happen.

// File: rtl/term_pkg.sv
package term_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GRANT, ST_WR_B0, ST_RD_B0, ST_WR_B1, ST_RD_B1, ST_WR_HI
  } term_st_e;

  localparam int BANK_BIT  = 5;
  localparam int SNS_A_BIT = 6;
  localparam int SNS_B_BIT = 7;
  localparam int AUTO_BIT  = 0;
  localparam int MLOW_BIT  = 2;
  localparam int MHIGH_BIT = 3;
endpackage

// File: rtl/grant_timer.sv
module grant_timer #(
  parameter int TICK_CYCLES = 100000,
  parameter int POLL_LIMIT  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sample_o,
  output logic last_o
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [TW-1:0] TICK_MAX = TW'(TICK_CYCLES - 1);
  localparam logic [PW-1:0] POLL_MAX = PW'(POLL_LIMIT - 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] poll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      poll_q <= '0;
    end else if (!run_i) begin
      tick_q <= '0;
      poll_q <= '0;
    end else begin
      tick_q <= (tick_q == TICK_MAX) ? '0 : tick_q + 1'b1;
      if (tick_q == '0 && poll_q != POLL_MAX) poll_q <= poll_q + 1'b1;
    end
  end

  assign sample_o = run_i && (tick_q == '0);
  assign last_o   = (poll_q == POLL_MAX);
endmodule

// File: rtl/bc_seq.sv
module bc_seq #(
  parameter int STEP_CYCLES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       rd_i,
  input  logic [7:0] val_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       cs_o,
  output logic       stb_o,
  output logic       rw_o,
  output logic [7:0] data_o
);
  localparam int HW = $clog2(STEP_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_MAX = HW'(STEP_CYCLES - 1);

  logic          active_q, rd_q;
  logic [1:0]    step_q;
  logic [HW-1:0] hold_q;
  logic [7:0]    val_q;
  logic          last_step;

  assign last_step = rd_q || (step_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      step_q   <= '0;
      hold_q   <= '0;
      val_q    <= '0;
    end else if (!active_q) begin
      if (go_i) begin
        active_q <= 1'b1;
        rd_q     <= rd_i;
        step_q   <= '0;
        hold_q   <= '0;
        if (!rd_i) val_q <= val_i;
      end
    end else if (hold_q == HOLD_MAX) begin
      hold_q <= '0;
      if (last_step) active_q <= 1'b0;
      else           step_q   <= step_q + 1'b1;
    end else begin
      hold_q <= hold_q + 1'b1;
    end
  end

  assign busy_o = active_q;
  assign done_o = active_q && (hold_q == HOLD_MAX) && last_step;
  assign cs_o   = active_q && (rd_q || step_q != 2'd3);
  assign stb_o  = active_q && !rd_q && !step_q[1];
  assign rw_o   = active_q && rd_q;
  // data is absent in the first write step and during reads
  assign data_o = (active_q && (rd_q || step_q == 2'd0)) ? 8'h00 : val_q;
endmodule

// File: rtl/term_decide.sv
module term_decide (
  input  logic p50_i,
  input  logic p68i_i,
  input  logic p68e_i,
  output logic high_o,
  output logic low_o,
  output logic bad_o
);
  logic [1:0] n_pop;
  assign n_pop  = {1'b0, p50_i} + {1'b0, p68i_i} + {1'b0, p68e_i};
  assign high_o = !p68i_i || !p68e_i;
  assign low_o  = (n_pop <= 2'd1);
  assign bad_o  = (n_pop == 2'd3);
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
  import term_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int POLL_LIMIT  = 1000,
  parameter int STEP_CYCLES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] adp_ctl_i,
  output logic        port_req_o,
  input  logic        port_rdy_i,
  output logic        bc_cs_o,
  output logic        bc_stb_o,
  output logic        bc_rw_o,
  output logic [7:0]  bc_wdata_o,
  input  logic [7:0]  bc_rdata_i,
  output logic        term_low_o,
  output logic        illegal_o,
  output logic        fail_o,
  output logic        done_o
);
  localparam int TICK_CYCLES = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam logic [7:0] BANK1_VAL = 8'(1 << BANK_BIT);
  localparam logic [7:0] HIGH_VAL  = 8'(1 << SNS_A_BIT);

  term_st_e st_q;
  logic auto_q, mlow_q, mhigh_q;
  logic p50_q, p68i_q, p68e_q;
  logic req_q, done_q, fail_q, low_q, bad_q;

  logic sample, last_poll;
  logic bc_go, bc_rd, bc_busy, bc_done;
  logic [7:0] bc_val;
  logic dec_high, dec_low, dec_bad, high_sel;
  logic op_state;

  logic unused_bits;
  assign unused_bits = ^{adp_ctl_i[15:4], adp_ctl_i[1], bc_rdata_i[5:0]};

  grant_timer #(.TICK_CYCLES(TICK_CYCLES), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_GRANT),
    .sample_o(sample), .last_o(last_poll)
  );

  term_decide u_dec (
    .p50_i(p50_q), .p68i_i(p68i_q), .p68e_i(p68e_q),
    .high_o(dec_high), .low_o(dec_low), .bad_o(dec_bad)
  );

  assign high_sel = auto_q ? dec_high : mhigh_q;
  assign op_state = (st_q == ST_WR_B0) || (st_q == ST_RD_B0) || (st_q == ST_WR_B1) ||
                    (st_q == ST_RD_B1) || (st_q == ST_WR_HI);
  assign bc_go    = op_state && !bc_busy;
  assign bc_rd    = (st_q == ST_RD_B0) || (st_q == ST_RD_B1);

  always_comb begin
    case (st_q)
      ST_WR_B1: bc_val = BANK1_VAL;
      ST_WR_HI: bc_val = high_sel ? HIGH_VAL : 8'h00;
      default:  bc_val = 8'h00;
    endcase
  end

  bc_seq #(.STEP_CYCLES(STEP_CYCLES)) u_bc (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(bc_go), .rd_i(bc_rd), .val_i(bc_val),
    .busy_o(bc_busy), .done_o(bc_done), .cs_o(bc_cs_o), .stb_o(bc_stb_o),
    .rw_o(bc_rw_o), .data_o(bc_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      auto_q  <= 1'b0;
      mlow_q  <= 1'b0;
      mhigh_q <= 1'b0;
      p50_q   <= 1'b0;
      p68i_q  <= 1'b0;
      p68e_q  <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      low_q   <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_GRANT;
          req_q   <= 1'b1;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          low_q   <= 1'b0;
          bad_q   <= 1'b0;
          auto_q  <= adp_ctl_i[AUTO_BIT];
          mlow_q  <= adp_ctl_i[MLOW_BIT];
          mhigh_q <= adp_ctl_i[MHIGH_BIT];
          p50_q   <= 1'b0;
          p68i_q  <= 1'b0;
          p68e_q  <= 1'b0;
        end
        ST_GRANT: if (sample) begin
          if (port_rdy_i) begin
            st_q <= auto_q ? ST_WR_B0 : ST_WR_HI;
          end else if (last_poll) begin
            st_q   <= ST_IDLE;
            req_q  <= 1'b0;
            fail_q <= 1'b1;
            done_q <= 1'b1;
          end
        end
        ST_WR_B0: if (bc_done) st_q <= ST_RD_B0;
        ST_RD_B0: if (bc_done) begin
          p50_q  <= !bc_rdata_i[SNS_A_BIT];
          p68i_q <= !bc_rdata_i[SNS_B_BIT];
          st_q   <= ST_WR_B1;
        end
        ST_WR_B1: if (bc_done) st_q <= ST_RD_B1;
        ST_RD_B1: if (bc_done) begin
          p68e_q <= !bc_rdata_i[SNS_A_BIT];
          st_q   <= ST_WR_HI;
        end
        ST_WR_HI: if (bc_done) begin
          st_q   <= ST_IDLE;
          req_q  <= 1'b0;
          done_q <= 1'b1;
          low_q  <= auto_q ? dec_low : mlow_q;
          bad_q  <= auto_q && dec_bad;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign port_req_o = req_q;
  assign term_low_o = low_q;
  assign illegal_o  = bad_q;
  assign fail_o     = fail_q;
  assign done_o     = done_q;
endmodule

// File: rtl/bus_term_ctrl_chk.sv
module bus_term_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic port_req_o,
  input logic bc_cs_o,
  input logic bc_stb_o,
  input logic bc_rw_o,
  input logic term_low_o,
  input logic illegal_o,
  input logic fail_o,
  input logic done_o
);
  AST_STB_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_stb_o |-> bc_cs_o); // R5
  AST_STB_FALLS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bc_stb_o) |-> bc_cs_o); // R5
  AST_READ_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bc_rw_o |-> (bc_cs_o && !bc_stb_o)); // R6
  AST_BC_HOLDS_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bc_cs_o || bc_stb_o || bc_rw_o) |-> port_req_o); // R2
  AST_FAIL_IS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (done_o && !term_low_o && !illegal_o)); // R3
  AST_DONE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !port_req_o); // R12
  AST_BAD_NO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !term_low_o); // R10
endmodule

bind bus_term_ctrl bus_term_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_req_o(port_req_o), .bc_cs_o(bc_cs_o),
  .bc_stb_o(bc_stb_o), .bc_rw_o(bc_rw_o), .term_low_o(term_low_o),
  .illegal_o(illegal_o), .fail_o(fail_o), .done_o(done_o)
);

// File: tb/sim_bus_term_ctrl.sv
module sim_bus_term_ctrl;
  localparam int CLK_HZ = 8000;
  localparam int TICK   = CLK_HZ / 1000;
  localparam int LIMIT  = 5;
  localparam int STEP   = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rdy = 1'b0;
  logic [15:0] adp = '0;
  logic req, cs, stb, rw, low, bad, fail, done;
  logic [7:0] wdata, rdata;
  logic [7:0] b0 = 8'hFF, b1 = 8'hFF;
  logic bank = 1'b0, hi_lat = 1'b0;

  int n_chk = 0, n_err = 0;
  int n_reads = 0, stb_len = 0;
  logic prev_stb = 1'b0, prev_rw = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  bus_term_ctrl #(.CLK_HZ(CLK_HZ), .POLL_LIMIT(LIMIT), .STEP_CYCLES(STEP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .adp_ctl_i(adp),
    .port_req_o(req), .port_rdy_i(rdy), .bc_cs_o(cs), .bc_stb_o(stb),
    .bc_rw_o(rw), .bc_wdata_o(wdata), .bc_rdata_i(rdata),
    .term_low_o(low), .illegal_o(bad), .fail_o(fail), .done_o(done)
  );

  assign rdata = bank ? b1 : b0;

  task automatic check(input string req_tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  // monitor: board model plus scoreboard of strobed writes
  always @(negedge clk) begin
    if (stb) stb_len <= stb_len + 1;
    if (prev_stb && !stb && cs) begin
      bank   <= wdata[5];
      hi_lat <= wdata[6];
      check("R5 strobe width", stb_len, 2 * STEP);
      if (exp_q.size() == 0) check("R3/R7 unexpected write", int'(wdata), -1);
      else check("R7/R8/R11 write value", int'(wdata), int'(exp_q.pop_front()));
      stb_len <= 0;
    end
    if (rw && !prev_rw) n_reads <= n_reads + 1;
    prev_stb <= stb;
    prev_rw  <= rw;
  end

  task automatic run_case(input string tag, input bit auto_m, input bit m_lo, input bit m_hi,
                          input bit p50, input bit p68i, input bit p68e, input int k);
    int cnt, lat, npop, rd_exp;
    bit hi_exp, lo_exp, bad_exp, early_drop;
    npop = int'(p50) + int'(p68i) + int'(p68e);
    b0 = {~p68i, ~p50, 6'b010101};
    b1 = {1'b1, ~p68e, 6'b101010};
    adp = {12'hC3A, m_hi, m_lo, 1'b1, auto_m};
    hi_exp  = auto_m ? (!p68i || !p68e) : m_hi;
    lo_exp  = auto_m ? (npop <= 1) : m_lo;
    bad_exp = auto_m && (npop == 3);
    if (k < 0) begin
      hi_exp = 0; lo_exp = 0; bad_exp = 0; rd_exp = 0;
      lat = 1 + (LIMIT - 1) * TICK;
    end else begin
      if (auto_m) begin
        exp_q.push_back(8'h00);
        exp_q.push_back(8'h20);
      end
      exp_q.push_back(hi_exp ? 8'h40 : 8'h00);
      rd_exp = auto_m ? 2 : 0;
      lat = (auto_m ? 6 + 14 * STEP : 2 + 4 * STEP) + k * TICK;
    end
    n_reads = 0;
    early_drop = 0;
    cnt = 0;
    rdy = (k == 0);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check({tag, " R2 request raised"}, int'(req), 1);
    while (1) begin
      rdy = (k >= 0) && (cnt >= k * TICK);
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (done) break;
      if (!req) early_drop = 1;
      if (cnt > 2000) break;
    end
    rdy = 1'b0;
    check({tag, " R12/R3/R4 latency"}, cnt, lat);
    check({tag, " R2 request held"}, int'(early_drop), 0);
    check({tag, " R12 released"}, int'(req), 0);
    check({tag, " R3 fail"}, int'(fail), (k < 0) ? 1 : 0);
    check({tag, " R9/R11 low term"}, int'(low), int'(lo_exp));
    check({tag, " R10 illegal"}, int'(bad), int'(bad_exp));
    check({tag, " R6/R11 reads"}, n_reads, rd_exp);
    check({tag, " R7 writes left"}, exp_q.size(), 0);
    if (k >= 0) check({tag, " R8 high latched"}, int'(hi_lat), int'(hi_exp));
    exp_q.delete();
    repeat (3) @(negedge clk);
    check({tag, " R12 result held"}, int'(low), int'(lo_exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", int'({req, cs, stb, rw, wdata, low, bad, fail, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'({req, done}), 0);
    run_case("auto none",     1, 0, 0, 0, 0, 0, 0);
    run_case("auto i68",      1, 0, 0, 0, 1, 0, 0);
    run_case("auto i68 e68",  1, 0, 0, 0, 1, 1, 0);
    run_case("auto i50 e68",  1, 0, 0, 1, 0, 1, 0);
    run_case("auto all R10",  1, 0, 0, 1, 1, 1, 0);
    run_case("man lo R11",    0, 1, 0, 1, 1, 1, 0);
    run_case("man hi R11",    0, 0, 1, 0, 0, 0, 0);
    run_case("late R4",       1, 0, 0, 1, 0, 0, 2);
    run_case("timeout R3",    1, 1, 1, 0, 0, 0, -1);
    run_case("after fail",    0, 1, 1, 0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule